// File: doc/BRIEF.md
# Maskable Interrupt and DMA Request Router

This block collects thirteen event flags from the rest of a card-interface controller and turns them into one interrupt line for the processor and two DMA request lines. The flags are kept in a request register. Other logic in the controller sets a flag with a one-cycle pulse on its bit of `setPulse`. Register reads, FIFO pops and software acknowledges clear flags through `clrPulse`. A thirteen-bit mask register decides which flags reach the interrupt line. A flag raises the interrupt only while its mask bit is clear.

The flags are assigned to bit positions as follows:

| Bit | Flag |
|-----|------|
| 0 | transfer finished |
| 1 | write programming finished |
| 2 | command cycle finished |
| 3 | stop command seen |
| 4 | clock stopped |
| 5 | receive FIFO wants service |
| 6 | transmit FIFO wants service |
| 7 | timer tick |
| 8 | data CRC or format error |
| 9 | response error |
| 10 | read stalled |
| 11 | card-raised interrupt |
| 12 | card acknowledge |

When DMA mode is selected, the two FIFO-service flags (bits 5 and 6) stop contributing to the processor interrupt. Bit 5 then drives the receive DMA request and bit 6 drives the transmit DMA request. This lets a DMA engine move the FIFO data without waking the CPU.

The current request and mask registers are brought out as plain state outputs so that the register bus around the block can read them. All three request outputs are registered.

Top module: `irq_dma_router`

## Requirements
- R1: While `rstN` is low, `reqState`, `maskState`, `irqOut`, `rxDmaReq` and `txDmaReq` are all zero.
- R2: A clock edge with `maskWrEn` high loads bits [12:0] of the 32-bit `maskWrData` into the mask, visible on `maskState` after that edge. Bits [31:13] are ignored. Without `maskWrEn` the mask keeps its value.
- R3: A high `setPulse[i]` at a clock edge makes `reqState[i]` one after that edge. The bit then stays one until it is cleared.
- R4: A high `clrPulse[i]` at a clock edge makes `reqState[i]` zero after that edge, unless `setPulse[i]` is high in the same cycle, in which case the set wins.
- R5: With DMA mode off, `irqOut` after an edge equals the OR over all bits of (`reqState` AND NOT `maskState`), taken as they were just before that edge. The interrupt therefore lags a request or mask change by one cycle.
- R6: With `dmaMode` high before an edge, request bits 5 and 6 are treated as masked for `irqOut` after that edge, whatever their mask bits hold.
- R7: With `dmaMode` high before an edge, `rxDmaReq` after the edge equals request bit 5 and `txDmaReq` equals request bit 6, both taken as they were before that edge.
- R8: With `dmaMode` low before an edge, `rxDmaReq` and `txDmaReq` are zero after that edge, whatever request bits 5 and 6 hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| maskWrEn | input | 1 | Load the mask register this cycle |
| maskWrData | input | 32 | Bus write data for the mask; only bits [12:0] are kept |
| setPulse | input | 13 | Per-flag set strobes from controller events |
| clrPulse | input | 13 | Per-flag clear strobes from register or FIFO activity |
| dmaMode | input | 1 | DMA-enable bit of the command/data control word |
| reqState | output | 13 | Current request register |
| maskState | output | 13 | Current mask register |
| irqOut | output | 1 | Registered combined processor interrupt |
| rxDmaReq | output | 1 | Registered receive DMA request |
| txDmaReq | output | 1 | Registered transmit DMA request |

## Verification
A flag that is lost, stuck or cleared when it should be set shows on `reqState` right after the offending edge. It reaches `irqOut` one edge later whenever its mask bit is clear.

A steering fault shows within one cycle of a `dmaMode` change, as either of the following:
- a FIFO-service flag still raising `irqOut`;
- a DMA line following the flag while DMA mode is off.

A mask that latched the wrong bit slice shows on `maskState` immediately after the write. The random phase keeps many flags pending under changing masks so that any gating error soon reaches the interrupt.

// File: rtl/irq_dma_router_pkg.sv
`timescale 1ns/1ps
package irq_dma_router_pkg;

  // Strobes handed from the control side to the datapath each cycle.
  typedef struct packed {
    logic maskLoad;  // capture new mask value at this edge
    logic dmaSteer;  // route FIFO-service flags to DMA lines
  } routerStrobes_t;

endpackage

// File: rtl/irq_dma_router_ctrl.sv
`timescale 1ns/1ps
module irq_dma_router_ctrl
  import irq_dma_router_pkg::*;
(
  input  logic           maskWrEn,
  input  logic           dmaMode,
  output routerStrobes_t strobes
);

  always_comb begin
    strobes.maskLoad = maskWrEn;
    strobes.dmaSteer = dmaMode;
  end

endmodule

// File: rtl/irq_dma_router_datapath.sv
`timescale 1ns/1ps
module irq_dma_router_datapath
  import irq_dma_router_pkg::*;
#(
  parameter int N_SRC  = 13,
  parameter int BUS_W  = 32,
  parameter int RX_POS = 5,
  parameter int TX_POS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  routerStrobes_t   strobes,
  input  logic [BUS_W-1:0] maskWrData,
  input  logic [N_SRC-1:0] setPulse,
  input  logic [N_SRC-1:0] clrPulse,
  output logic [N_SRC-1:0] reqQ,
  output logic [N_SRC-1:0] maskQ,
  output logic             irqQ,
  output logic             rxQ,
  output logic             txQ
);

  localparam logic [N_SRC-1:0] STEER_BITS =
    (N_SRC'(1) << RX_POS) | (N_SRC'(1) << TX_POS);

  logic [N_SRC-1:0] effMask;
  logic             anyPending;

  // Per-flag request storage; a set in the same cycle beats a clear.
  for (genvar b = 0; b < N_SRC; b++) begin : g_req
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            reqQ[b] <= 1'b0;
      else if (setPulse[b]) reqQ[b] <= 1'b1;
      else if (clrPulse[b]) reqQ[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 maskQ <= '0;
    else if (strobes.maskLoad) maskQ <= maskWrData[N_SRC-1:0];
  end

  always_comb begin
    effMask    = maskQ | (strobes.dmaSteer ? STEER_BITS : '0);
    anyPending = |(reqQ & ~effMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
      rxQ  <= 1'b0;
      txQ  <= 1'b0;
    end else begin
      irqQ <= anyPending;
      rxQ  <= strobes.dmaSteer & reqQ[RX_POS];
      txQ  <= strobes.dmaSteer & reqQ[TX_POS];
    end
  end

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.maskLoad) |-> maskQ == $past(maskWrData[N_SRC-1:0]));

  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (setPulse != '0) |=> ((reqQ & $past(setPulse)) == $past(setPulse)));

  assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((clrPulse & ~setPulse) != '0) |=> ((reqQ & $past(clrPulse & ~setPulse)) == '0));

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((reqQ & ~maskQ) == '0) |=> !irqQ);

  assert_rx_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dmaSteer |=> rxQ == $past(reqQ[RX_POS]));

  assert_dma_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dmaSteer |=> (!rxQ && !txQ));

endmodule

// File: rtl/irq_dma_router.sv
`timescale 1ns/1ps
module irq_dma_router
  import irq_dma_router_pkg::*;
#(
  parameter int N_SRC  = 13,
  parameter int BUS_W  = 32,
  parameter int RX_POS = 5,
  parameter int TX_POS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             maskWrEn,
  input  logic [BUS_W-1:0] maskWrData,
  input  logic [N_SRC-1:0] setPulse,
  input  logic [N_SRC-1:0] clrPulse,
  input  logic             dmaMode,
  output logic [N_SRC-1:0] reqState,
  output logic [N_SRC-1:0] maskState,
  output logic             irqOut,
  output logic             rxDmaReq,
  output logic             txDmaReq
);

  routerStrobes_t strobes;

  irq_dma_router_ctrl u_ctrl (
    .maskWrEn (maskWrEn),
    .dmaMode  (dmaMode),
    .strobes  (strobes)
  );

  irq_dma_router_datapath #(
    .N_SRC  (N_SRC),
    .BUS_W  (BUS_W),
    .RX_POS (RX_POS),
    .TX_POS (TX_POS)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .maskWrData (maskWrData),
    .setPulse   (setPulse),
    .clrPulse   (clrPulse),
    .reqQ       (reqState),
    .maskQ      (maskState),
    .irqQ       (irqOut),
    .rxQ        (rxDmaReq),
    .txQ        (txDmaReq)
  );

endmodule

// File: tb/irq_dma_router_bench.sv
`timescale 1ns/1ps
module irq_dma_router_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        maskWrEn;
  logic [31:0] maskWrData;
  logic [12:0] setPulse;
  logic [12:0] clrPulse;
  logic        dmaMode;
  logic [12:0] reqState;
  logic [12:0] maskState;
  logic        irqOut;
  logic        rxDmaReq;
  logic        txDmaReq;

  int checks = 0;
  int errors = 0;

  logic [12:0] expReq;
  logic [12:0] expMask;
  logic        expIrq;
  logic        expRx;
  logic        expTx;

  always #2.5 clk = ~clk;

  irq_dma_router u_irq_dma_router (
    .clk        (clk),
    .rstN       (rstN),
    .maskWrEn   (maskWrEn),
    .maskWrData (maskWrData),
    .setPulse   (setPulse),
    .clrPulse   (clrPulse),
    .dmaMode    (dmaMode),
    .reqState   (reqState),
    .maskState  (maskState),
    .irqOut     (irqOut),
    .rxDmaReq   (rxDmaReq),
    .txDmaReq   (txDmaReq)
  );

  // Reference values derived from the requirements.
  function automatic logic [12:0] nextReq(logic [12:0] cur,
                                          logic [12:0] s,
                                          logic [12:0] c);
    return (cur & ~c) | s;  // R3 set, R4 clear, set wins
  endfunction

  function automatic logic irqFrom(logic [12:0] r, logic [12:0] m, logic dma);
    logic [12:0] hidden;
    hidden = m | (dma ? 13'h0060 : 13'h0000);  // R6 bits 5 and 6
    return |(r & ~hidden);                      // R5
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expReq  <= '0;
      expMask <= '0;
      expIrq  <= 1'b0;
      expRx   <= 1'b0;
      expTx   <= 1'b0;
    end else begin
      expReq <= nextReq(expReq, setPulse, clrPulse);
      if (maskWrEn) expMask <= maskWrData[12:0];
      expIrq <= irqFrom(expReq, expMask, dmaMode);
      expRx  <= dmaMode & expReq[5];
      expTx  <= dmaMode & expReq[6];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkModel();
    check("R3 reqState",  32'(reqState),  32'(expReq));
    check("R2 maskState", 32'(maskState), 32'(expMask));
    check("R5 irqOut",    32'(irqOut),    32'(expIrq));
    check("R7 rxDmaReq",  32'(rxDmaReq),  32'(expRx));
    check("R7 txDmaReq",  32'(txDmaReq),  32'(expTx));
  endtask

  task automatic idle();
    maskWrEn   = 1'b0;
    maskWrData = '0;
    setPulse   = '0;
    clrPulse   = '0;
  endtask

  // One cycle: inputs already set at a negedge; advance to the next negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240613));
    rstN    = 1'b0;
    dmaMode = 1'b0;
    idle();
    repeat (3) @(negedge clk);

    // R1: all outputs zero under reset
    check("R1 reqState",  32'(reqState),  32'h0);
    check("R1 maskState", 32'(maskState), 32'h0);
    check("R1 irq/dma",
          32'({irqOut, rxDmaReq, txDmaReq}), 32'h0);
    rstN = 1'b1;
    step();

    // R2: only bits [12:0] of the bus data are kept
    maskWrEn   = 1'b1;
    maskWrData = 32'hFFFF_A5A5;
    step();
    idle();
    check("R2 mask low bits", 32'(maskState), 32'h05A5);
    step();
    check("R2 mask held", 32'(maskState), 32'h05A5);

    maskWrEn   = 1'b1;
    maskWrData = 32'h0;
    step();
    idle();

    // R3 and R5: set bit 2, interrupt one cycle after the request
    setPulse = 13'h0004;
    step();
    idle();
    check("R3 set bit2", 32'(reqState), 32'h0004);
    check("R5 irq lags", 32'(irqOut), 32'h0);
    step();
    check("R5 irq high", 32'(irqOut), 32'h1);
    check("R3 bit2 sticks", 32'(reqState), 32'h0004);

    // R4: set and clear together on bit 2 keep it; clear alone drops it
    setPulse = 13'h0004;
    clrPulse = 13'h0004;
    step();
    idle();
    check("R4 set wins", 32'(reqState), 32'h0004);
    clrPulse = 13'h0004;
    step();
    idle();
    check("R4 cleared", 32'(reqState), 32'h0);
    step();
    check("R5 irq low after clear", 32'(irqOut), 32'h0);

    // R6, R7: DMA mode hides bit 5 from irq and drives rx line
    dmaMode  = 1'b1;
    setPulse = 13'h0020;
    step();
    idle();
    step();
    check("R6 irq hidden", 32'(irqOut), 32'h0);
    check("R7 rx follows", 32'(rxDmaReq), 32'h1);
    check("R7 tx idle", 32'(txDmaReq), 32'h0);

    // R8: DMA mode off returns bit 5 to irq and silences DMA lines
    dmaMode = 1'b0;
    step();
    check("R8 rx low", 32'(rxDmaReq), 32'h0);
    check("R8 irq back", 32'(irqOut), 32'h1);

    // Random phase against the reference model
    for (int n = 0; n < 3000; n++) begin
      setPulse = 13'($urandom & $urandom & $urandom);
      clrPulse = 13'($urandom & $urandom);
      maskWrEn = ($urandom % 8) == 0;
      maskWrData = $urandom;
      if (($urandom % 16) == 0) dmaMode = ~dmaMode;
      step();
      checkModel();
    end

    idle();
    step();
    checkModel();
    finishRun();
  end

endmodule